// File: doc/BRIEF.md
# Programmable Half-Duty Master Clock Divider

The block takes a reference clock and divides it by an integer M, chosen from 1 to 16, to produce the master clock for an audio codec and for the codec port logic. The output has an equal high and low time for every M. This includes odd values of M, where the output edges fall on both edges of the reference. With M = 1 the reference itself is passed to the output. The reference is expected to lie between 12 and 25 MHz, so the divided clock covers roughly 750 kHz up to 25 MHz.

A plain select input steers the codec port clock. It picks either the divided clock or an externally supplied master clock. The divider keeps running while the external clock is selected, so switching back does not restart it.

The divisor is written as a 4-bit code equal to M-1. A new code takes effect only where an output period ends. A synchronous reset holds the divided output low.

Top module: `mdiv_top`

## Requirements
- R1: The divided output `mclk_div` has a period of exactly M reference cycles, where M = `div_code` + 1 and `div_code` runs from 0 to 15.
- R2: Each output period begins with a rising edge of `mclk_div` at a rising edge of `clk_ref`. The output stays high for exactly M reference half-cycles and low for the other M.
- R3: With `div_code` = 0, `mclk_div` equals `clk_ref` once the block is running.
- R4: For odd M, `mclk_div` falls at a falling edge of `clk_ref`, half a reference cycle after the last rising edge on which it was high.
- R5: `div_code` is sampled only at the rising edge of `clk_ref` that ends the current output period. A change made at any other time has no effect until that edge.
- R6: While `rst_ref` is high at a rising edge of `clk_ref`, `mclk_div` is low after that edge. The first period after release starts at the first rising edge with `rst_ref` low and uses the `div_code` present at that edge.
- R7: `codec_clk` equals `ext_mclk` when `sel_ext` is 1 and equals `mclk_div` when `sel_ext` is 0.
- R8: `sel_ext` has no effect on `mclk_div`. The divider keeps its count and phase while the external clock is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock from the frequency synthesizer |
| rst_ref | input | 1 | Synchronous reset, active high |
| div_code | input | DIV_W (4) | Divisor code, M - 1 |
| ext_mclk | input | 1 | External master clock |
| sel_ext | input | 1 | 1 selects ext_mclk for codec_clk |
| mclk_div | output | 1 | Divided master clock |
| codec_clk | output | 1 | Clock for the codec port |

## Verification
The bench builds the block with the default 4-bit divisor field. With that width, every divisor from 1 to 16 can be reached, and the sweep visits each odd and even value, including both limits. The reference model advances one half-cycle at a time and samples in both halves of each reference cycle, so falling edges placed on the falling reference edge are checked exactly. The external clock runs at a period that is not a multiple of the reference, and its edges never coincide with a sample point, so the select path is checked across many phase relations.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_EVEN = 2'd1,
    MODE_ODD  = 2'd2
  } mdiv_mode_e;

  // Number of rising-edge cycles the rising counter output stays high.
  function automatic int high_cycles(input int code);
    return (code + 1) / 2;
  endfunction

  function automatic mdiv_mode_e mode_of(input int code);
    if (code == 0)        return MODE_PASS;
    else if (code[0])     return MODE_EVEN;
    else                  return MODE_ODD;
  endfunction

endpackage

// File: rtl/mdiv_rise_ctr.sv
module mdiv_rise_ctr #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_code,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] m_act,
  output logic             q_pos,
  output logic             run
);
  localparam int HW = DIV_W + 1;

  logic             at_end;
  logic [DIV_W-1:0] nxt_cnt;
  logic [DIV_W-1:0] nxt_m;
  logic [HW-1:0]    nxt_high;

  always_comb begin
    at_end   = (cnt == m_act);
    nxt_cnt  = at_end ? '0 : cnt + 1'b1;
    nxt_m    = at_end ? div_code : m_act;
    nxt_high = HW'(mdiv_pkg::high_cycles(int'(nxt_m)));
  end

  // During reset the counter sits on its last count so the first
  // released edge is a period boundary that loads a fresh divisor.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= div_code;
      m_act <= div_code;
      q_pos <= 1'b0;
      run   <= 1'b0;
    end else begin
      cnt   <= nxt_cnt;
      m_act <= nxt_m;
      q_pos <= ({1'b0, nxt_cnt} < nxt_high);
      run   <= 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= m_act); // R1
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt != m_act) |=> (m_act == $past(m_act))); // R5
  AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(q_pos) |-> (cnt == '0)); // R2

endmodule

// File: rtl/mdiv_fall_stage.sv
module mdiv_fall_stage (
  input  logic clk,
  input  logic rst,
  input  logic q_pos,
  output logic q_neg
);
  always_ff @(negedge clk) begin
    if (rst) q_neg <= 1'b0;
    else     q_neg <= q_pos;
  end

  AST_FALL_FOLLOWS_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(q_neg) |-> q_pos); // R4

endmodule

// File: rtl/mdiv_combine.sv
module mdiv_combine #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             run,
  input  logic [DIV_W-1:0] m_act,
  input  logic             q_pos,
  input  logic             q_neg,
  output logic             clk_o
);
  import mdiv_pkg::*;

  mdiv_mode_e mode;
  logic       raw;

  always_comb begin
    mode = mode_of(int'(m_act));
    case (mode)
      MODE_PASS: raw = clk;
      MODE_EVEN: raw = q_pos;
      MODE_ODD:  raw = q_pos | q_neg;
      default:   raw = 1'b0;
    endcase
    clk_o = run & raw;
  end

endmodule

// File: rtl/mdiv_top.sv
module mdiv_top #(
  parameter int DIV_W = 4
) (
  input  logic             clk_ref,
  input  logic             rst_ref,
  input  logic [DIV_W-1:0] div_code,
  input  logic             ext_mclk,
  input  logic             sel_ext,
  output logic             mclk_div,
  output logic             codec_clk
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] m_act;
  logic             q_pos;
  logic             q_neg;
  logic             run;

  mdiv_rise_ctr #(.DIV_W(DIV_W)) u_rise (
    .clk      (clk_ref),
    .rst      (rst_ref),
    .div_code (div_code),
    .cnt      (cnt),
    .m_act    (m_act),
    .q_pos    (q_pos),
    .run      (run)
  );

  mdiv_fall_stage u_fall (
    .clk   (clk_ref),
    .rst   (rst_ref),
    .q_pos (q_pos),
    .q_neg (q_neg)
  );

  mdiv_combine #(.DIV_W(DIV_W)) u_comb (
    .clk   (clk_ref),
    .run   (run),
    .m_act (m_act),
    .q_pos (q_pos),
    .q_neg (q_neg),
    .clk_o (mclk_div)
  );

  assign codec_clk = sel_ext ? ext_mclk : mclk_div;

endmodule

// File: tb/mdiv_top_tb_top.sv
`timescale 1ns/10ps
module mdiv_top_tb_top;
  logic       clk_ref = 1'b0;
  logic       rst_ref = 1'b1;
  logic [3:0] div_code = 4'd3;
  logic       ext_mclk = 1'b0;
  logic       sel_ext = 1'b0;
  logic       mclk_div;
  logic       codec_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_cur = 1;
  int pos   = 0;
  bit live  = 0;
  bit fresh = 0;

  mdiv_top #(.DIV_W(4)) dut_i (
    .clk_ref   (clk_ref),
    .rst_ref   (rst_ref),
    .div_code  (div_code),
    .ext_mclk  (ext_mclk),
    .sel_ext   (sel_ext),
    .mclk_div  (mclk_div),
    .codec_clk (codec_clk)
  );

  always #4 clk_ref = ~clk_ref;

  initial begin
    #0.25;
    forever #5.5 ext_mclk = ~ext_mclk;
  end

  always @(posedge clk_ref) begin
    if (rst_ref) begin
      live  = 0;
      fresh = 0;
    end else if (!live || pos == m_cur - 1) begin
      fresh = live && (int'(div_code) + 1 != m_cur);
      live  = 1;
      pos   = 0;
      m_cur = int'(div_code) + 1;
    end else begin
      pos++;
    end
  end

  function automatic string tag_of(bit in_rst);
    if (in_rst || !live) return "R6";
    if (m_cur == 1)      return "R3";
    if (fresh)           return "R5";
    if (m_cur % 2 == 1)  return "R4";
    return "R1/R2";
  endfunction

  task automatic check_half(input bit second);
    bit    exp_div;
    bit    exp_cc;
    string t;
    exp_div = live && ((2 * pos + (second ? 1 : 0)) < m_cur);
    t = tag_of(rst_ref);
    if (sel_ext) t = {t, "+R8"};
    checks++;
    if (mclk_div !== exp_div) begin
      fails++;
      $display("FAIL %s mclk_div t=%0t got %0b exp %0b (M=%0d pos=%0d)",
               t, $time, mclk_div, exp_div, m_cur, pos);
    end
    exp_cc = sel_ext ? ext_mclk : exp_div;
    checks++;
    if (codec_clk !== exp_cc) begin
      fails++;
      $display("FAIL R7 codec_clk t=%0t got %0b exp %0b", $time, codec_clk, exp_cc);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_ref); #2; if (!done) check_half(0);
      @(negedge clk_ref); #2; if (!done) check_half(1);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk_ref);
  endtask

  task automatic set_code(input int v);
    @(negedge clk_ref); #1; div_code = v[3:0];
  endtask

  initial begin
    cycles(4);
    @(negedge clk_ref); #1; rst_ref = 1'b0;   // R6 release with M=4
    cycles(40);
    // R1 R2 R3 R4 sweep of every code; R5 changes land mid-period
    for (int v = 0; v < 16; v++) begin
      set_code(v);
      cycles(3 * (v + 1) + 5);
    end
    // R6 reset in mid period with an odd divisor
    set_code(2);
    cycles(5);
    @(negedge clk_ref); #1; rst_ref = 1'b1; div_code = 4'd6;
    cycles(3);
    @(negedge clk_ref); #1; rst_ref = 1'b0;
    cycles(30);
    // R7 R8 external clock selected while divisor changes
    @(negedge clk_ref); #1; sel_ext = 1'b1;
    cycles(20);
    set_code(4);
    cycles(25);
    @(negedge clk_ref); #1; sel_ext = 1'b0;
    cycles(20);
    // R3 R5 transitions into and out of pass-through
    set_code(0);  cycles(12);
    set_code(1);  cycles(9);
    set_code(0);  cycles(6);
    set_code(15); cycles(40);
    set_code(0);  cycles(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cycles(150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule